// File: doc/BRIEF.md
# Packed-Word Chained Left/Right-Zero LLR Unit

This unit is one stage of the datapath in a fast simplified successive-cancellation polar decoder. It covers the tree stages that are smaller than the decoder's processing width. In that part of the tree, the soft values (LLRs) for every low stage are packed into one memory word. Each region in the word is half the size of the region above it. A read of this word hands the unit every stage it may need, so the unit can run one, two or three tree descents in a single clock cycle. The descents are either all left-message (F) operations or all right-message operations with a zero left partial sum (G0).

Each cycle the unit takes a packed word, a wide input, an opcode, a repeat count and a start stage. One cycle later it returns the updated packed word with one write-enable per region. For a chained F, every level of the chain writes its result, because later instructions read those nodes again. For a chained G0, only the deepest result is written. The wide input carries 2·PE LLRs. It feeds chains that begin one stage above the packed word, and it also serves single operations on large nodes, processed one 2·PE chunk at a time. Those single operations return their PE results on a separate port. An illegal request raises an error flag and writes nothing.

Top module: `polar_fg0_chain`

## Requirements
- R1: With PE = 64 and 6-bit two's-complement LLRs, region k of the packed word (k = 0..4) holds stage 6−k and has PE>>k LLRs. It starts at LLR offset 2·PE − (2·PE>>k), and LLR j of the word occupies bits [6j+5:6j]. Region write-enable bit k belongs to region k.
- R2: The F operation (op = 0) on a node of n LLRs produces n/2 outputs. Output i is min(|a|,|b|), negated when exactly one of a = LLR i and b = LLR i+n/2 is negative. A positive result of 32 saturates to 31.
- R3: The G0 operation (op = 1) gives output i = a + b, saturated to the range −32..31.
- R4: A chained F with count c (1..3) starting at stage s ≤ 6 reads region 6−s. It writes the regions of stages s−1 down to s−c, and each level is computed from the level above it.
- R5: A chained G0 with count c writes only the region of stage s−c. The intermediate regions keep their write-enables low, and the output word holds the input values there.
- R6: Start stage 7 takes its node from the wide input, with a = LLR i and b = LLR i+64, and writes its first result into region 0. From stage 7, a G0 may chain up to 3 levels, while an F is limited to count 1.
- R7: A start stage above 7 with count 1 applies the operation to the 128-LLR wide input. It returns 64 results on the high-result port with its write-enable set, and writes no region.
- R8: A request is rejected, with err = 1 and every write-enable low, in any of these cases: the count is 0; s − c < 2; the count is not 1 above stage 7; or an F at stage 7 has a count above 1.
- R9: Outputs appear exactly one cycle after a valid request. Regions that are not written equal the input word. When no request was made, valid, err and all write-enables are low.
- R10: During and right after reset, valid, err and all write-enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request valid |
| op | input | 1 | 0 = F, 1 = G0 |
| cnt | input | 2 | Repeat count, 1..3 legal |
| stage | input | 4 | Start stage of the node |
| pk_in | input | 744 | Packed low-stage word |
| hi_in | input | 768 | Wide input, 2·PE LLRs |
| out_vld | output | 1 | Result valid |
| err | output | 1 | Request rejected |
| pk_out | output | 744 | Updated packed word |
| pk_we | output | 5 | Per-region write-enable |
| hi_res | output | 384 | PE results of a high-stage single operation |
| hi_we | output | 1 | hi_res is valid |

## Verification
The bench drives every count at every start stage, including the edges of the legal range. Starting at stage 3 writes the smallest region, and starting at stage 2 must be rejected. A unit that gets this boundary wrong would either corrupt the word or refuse a legal descent. The bench also uses the stage-7 entry with both opcodes; a unit with the wrong wide-input half split, or one that accepts an F chain from stage 7, shows up in region 0. Inputs fixed at −32 and +31 drive F to its +32 magnitude overflow and G0 past both rails, so a unit that wraps instead of saturating fails. For each G0 chain, the bench checks that the intermediate regions keep their input values and have their enables low; a unit that stored them would break that.

// File: rtl/polar_fg0_chain.sv
`timescale 1ns/1ps
module polar_fg0_chain #(
  parameter int PE  = 64,
  parameter int W   = 6,
  parameter int STW = 4,
  localparam int LP   = $clog2(PE),
  localparam int NR   = LP - 1,
  localparam int NLLR = 2*PE - ((2*PE) >> NR),
  localparam int PKW  = NLLR * W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              op,
  input  logic [1:0]        cnt,
  input  logic [STW-1:0]    stage,
  input  logic [PKW-1:0]    pk_in,
  input  logic [2*PE*W-1:0] hi_in,
  output logic              out_vld,
  output logic              err,
  output logic [PKW-1:0]    pk_out,
  output logic [NR-1:0]     pk_we,
  output logic [PE*W-1:0]   hi_res,
  output logic              hi_we
);

  function automatic logic [W-1:0] f_op(input logic [W-1:0] a, input logic [W-1:0] b);
    int ia, ib, ma, mb, m, r;
    ia = int'($signed(a));
    ib = int'($signed(b));
    ma = (ia < 0) ? -ia : ia;
    mb = (ib < 0) ? -ib : ib;
    m  = (ma < mb) ? ma : mb;
    if ((ia < 0) != (ib < 0)) r = -m;
    else if (m > (2**(W-1)) - 1) r = (2**(W-1)) - 1;
    else r = m;
    return W'(r);
  endfunction

  function automatic logic [W-1:0] g_op(input logic [W-1:0] a, input logic [W-1:0] b);
    int s;
    s = int'($signed(a)) + int'($signed(b));
    if (s > (2**(W-1)) - 1) s = (2**(W-1)) - 1;
    if (s < -(2**(W-1))) s = -(2**(W-1));
    return W'(s);
  endfunction

  int s_i, c_i, sk;
  logic bad, go;
  logic [NR-1:0] wen;
  logic [PKW-1:0] nxt;

  assign s_i = int'(stage);
  assign c_i = int'(cnt);
  assign sk  = LP - s_i;

  assign bad = (c_i == 0) ||
               (s_i > LP + 1 && c_i != 1) ||
               (s_i == LP + 1 && !op && c_i > 1) ||
               (s_i - c_i < 2);
  assign go  = in_vld && !bad;

  always_comb begin
    wen = '0;
    for (int k = 0; k < NR; k++) begin
      if (!op) wen[k] = (k > sk) && (k <= sk + c_i);
      else     wen[k] = (k == sk + c_i);
    end
    if (!go) wen = '0;
  end

  for (genvar k = 0; k < NR; k++) begin : g_rg
    localparam int N  = PE >> k;
    localparam int OF = 2*PE - ((2*PE) >> k);
    logic [2*N*W-1:0] par;
    logic [N*W-1:0]   res;
    if (k == 0) begin : g_top
      assign par = hi_in;
    end else begin : g_low
      localparam int PO = 2*PE - ((2*PE) >> (k-1));
      assign par = (sk == k - 1) ? pk_in[PO*W +: 2*N*W] : g_rg[k-1].res;
    end
    for (genvar i = 0; i < N; i++) begin : g_ll
      logic [W-1:0] a, b;
      assign a = par[i*W +: W];
      assign b = par[(i+N)*W +: W];
      assign res[i*W +: W] = op ? g_op(a, b) : f_op(a, b);
    end
    assign nxt[OF*W +: N*W] = wen[k] ? res : pk_in[OF*W +: N*W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      err     <= 1'b0;
      pk_we   <= '0;
      hi_we   <= 1'b0;
    end else begin
      out_vld <= in_vld;
      err     <= in_vld && bad;
      pk_we   <= wen;
      hi_we   <= go && (s_i > LP + 1);
    end
  end

  always_ff @(posedge clk) begin
    pk_out <= nxt;
    hi_res <= g_rg[0].res;
  end

endmodule

module polar_fg0_chain_chk #(parameter int NR = 5) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic          op,
  input logic [1:0]    cnt,
  input logic          out_vld,
  input logic          err,
  input logic [NR-1:0] pk_we,
  input logic          hi_we
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !out_vld |-> (pk_we == '0 && !hi_we && !err)); // R9
  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_vld); // R9
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) err |-> (pk_we == '0 && !hi_we)); // R8
  AST_ZERO_CNT_ERR: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && cnt == 2'd0) |=> err); // R8
  AST_G0_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && op) |=> $onehot0(pk_we)); // R5
  AST_F_WRITES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && !op) |=> ($countones(pk_we) <= int'($past(cnt)))); // R4
  AST_HI_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) hi_we |-> pk_we == '0); // R7
endmodule

bind polar_fg0_chain polar_fg0_chain_chk #(.NR(NR)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .cnt(cnt),
  .out_vld(out_vld), .err(err), .pk_we(pk_we), .hi_we(hi_we)
);

// File: tb/sim_polar_fg0_chain.sv
`timescale 1ns/1ps
module sim_polar_fg0_chain;
  localparam int PE = 64, W = 6, STW = 4;
  localparam int LP = 6, NR = 5, NLLR = 124, PKW = NLLR*W, BW = 2*PE*W;

  logic clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0, op = 1'b0;
  logic [1:0] cnt = '0;
  logic [STW-1:0] stage = '0;
  logic [PKW-1:0] pk_in = '0;
  logic [BW-1:0] hi_in = '0;
  logic out_vld, err, hi_we;
  logic [PKW-1:0] pk_out;
  logic [NR-1:0] pk_we;
  logic [PE*W-1:0] hi_res;

  polar_fg0_chain u0 (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int pin[NLLR], win[2*PE], e_pk[NLLR], e_hi[PE];
  bit e_vld = 0, e_err = 0, e_hiwe = 0;
  logic [NR-1:0] e_we = '0;
  string e_tag = "R10";

  function automatic int roff(int k); return 2*PE - ((2*PE) >> k); endfunction
  function automatic int fm(int a, int b);
    int ma = a < 0 ? -a : a, mb = b < 0 ? -b : b, m;
    m = ma < mb ? ma : mb;
    if ((a < 0) != (b < 0)) return -m;
    return m > 31 ? 31 : m;
  endfunction
  function automatic int gs(int a, int b);
    int s = a + b;
    return s > 31 ? 31 : (s < -32 ? -32 : s);
  endfunction

  task automatic check(bit ok, string tag, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [PKW-1:0] ev;
    logic [PE*W-1:0] eh;
    logic [3+NR:0] ac, ec;
    ac = {out_vld, err, hi_we, pk_we};
    ec = {e_vld, e_err, e_hiwe, e_we};
    check(ac === ec, e_tag, "control{vld,err,hi_we,pk_we}", BW'(ac), BW'(ec));
    if (e_vld) begin
      for (int j = 0; j < NLLR; j++) ev[j*W +: W] = W'(e_pk[j]);
      check(pk_out === ev, e_tag, "pk_out", BW'(pk_out), BW'(ev));
    end
    if (e_hiwe) begin
      for (int j = 0; j < PE; j++) eh[j*W +: W] = W'(e_hi[j]);
      check(hi_res === eh, e_tag, "hi_res", BW'(hi_res), BW'(eh));
    end
  endtask

  task automatic step(bit v, bit o, int c, int s, int fill, string tag);
    int src[$], nr[$];
    bit bd;
    @(negedge clk);
    compare();
    for (int j = 0; j < NLLR; j++) pin[j] = fill == 1 ? -32 : (fill == 2 ? 31 : int'($urandom_range(0, 63)) - 32);
    for (int j = 0; j < 2*PE; j++) win[j] = fill == 1 ? -32 : (fill == 2 ? 31 : int'($urandom_range(0, 63)) - 32);
    for (int j = 0; j < NLLR; j++) pk_in[j*W +: W] = W'(pin[j]);
    for (int j = 0; j < 2*PE; j++) hi_in[j*W +: W] = W'(win[j]);
    in_vld = v; op = o; cnt = 2'(c); stage = STW'(s);
    bd = (c == 0) || (s > LP+1 && c != 1) || (s == LP+1 && !o && c > 1) || (s - c < 2);
    e_vld = v; e_err = v && bd; e_we = '0; e_hiwe = 0; e_tag = tag;
    for (int j = 0; j < NLLR; j++) e_pk[j] = pin[j];
    if (v && !bd) begin
      if (s > LP) for (int j = 0; j < 2*PE; j++) src.push_back(win[j]);
      else for (int j = 0; j < (1 << s); j++) src.push_back(pin[roff(LP-s) + j]);
      for (int l = 1; l <= c; l++) begin
        int h = src.size() / 2;
        nr.delete();
        for (int i = 0; i < h; i++) nr.push_back(o ? gs(src[i], src[i+h]) : fm(src[i], src[i+h]));
        if (s - l <= LP && (!o || l == c)) begin
          for (int i = 0; i < h; i++) e_pk[roff(LP-(s-l)) + i] = nr[i];
          e_we[LP-(s-l)] = 1'b1;
        end
        if (s > LP+1) begin
          for (int i = 0; i < PE; i++) e_hi[i] = nr[i];
          e_hiwe = 1;
        end
        src = nr;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({out_vld, err, hi_we, pk_we} === '0, "R10", "reset outputs", BW'({out_vld, err, hi_we, pk_we}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check({out_vld, err, hi_we, pk_we} === '0, "R10", "after reset", BW'({out_vld, err, hi_we, pk_we}), '0);
    step(1, 0, 1, 6, 0, "R2");
    step(1, 0, 3, 6, 0, "R4");
    step(1, 0, 2, 4, 0, "R4");
    step(1, 0, 3, 5, 0, "R4");
    step(1, 1, 1, 6, 0, "R3");
    step(1, 1, 3, 6, 0, "R5");
    step(1, 1, 2, 4, 0, "R5");
    step(0, 0, 1, 6, 0, "R5");
    step(1, 1, 3, 7, 0, "R6");
    step(1, 0, 1, 7, 0, "R6");
    step(1, 0, 2, 7, 0, "R8");
    step(1, 0, 1, 9, 0, "R7");
    step(1, 1, 1, 10, 0, "R7");
    step(1, 1, 2, 8, 0, "R8");
    step(1, 0, 0, 6, 0, "R8");
    step(1, 1, 3, 4, 0, "R8");
    step(1, 0, 1, 3, 0, "R1");
    step(1, 1, 1, 2, 0, "R8");
    step(1, 0, 2, 6, 1, "R2");
    step(1, 1, 2, 5, 1, "R3");
    step(1, 1, 1, 7, 2, "R3");
    step(0, 1, 1, 7, 0, "R9");
    for (int t = 0; t < 400; t++) begin
      bit v = $urandom_range(0, 7) != 0;
      bit o = 1'($urandom_range(0, 1));
      int c = $urandom_range(0, 3), s = $urandom_range(2, 10);
      bit bd = (c == 0) || (s > LP+1 && c != 1) || (s == LP+1 && !o && c > 1) || (s - c < 2);
      string tg = !v ? "R9" : bd ? "R8" : s > LP+1 ? "R7" : s == LP+1 ? "R6" : o ? "R5" : "R4";
      step(v, o, c, s, 0, tg);
    end
    step(0, 0, 1, 6, 0, "R9");
    step(0, 0, 1, 6, 0, "R9");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule